// File: doc/BRIEF.md
# Programmable Output Vertical Sync Delay Generator

The block generates an output vertical sync (OVS) that trails an input frame event by a programmable number of half-line steps. It also produces its own output horizontal sync (OHS). A free-running pixel counter wraps at a programmable line length. The counter's start point and its midpoint are the two half-line ticks of each line. A line-rate reference input can pull that counter back to position 0. The frame event is the rising edge of either the input vertical sync or an external trigger. A mode bit chooses which one.

After the programmed number of half-line ticks has passed, the block waits for the next line start. It then counts an 8-bit pixel offset and raises OVS for one line period, so OVS lands a fixed number of clocks after an OHS rise. When the asynchronous and interlace mode flags are both set, the programmed delay is replaced by zero. Settings arrive through a plain single-cycle register write port. Delay, offset, OHS width and mode flags are staged and only applied at the next frame event, so a frame in progress never changes timing part-way through.

Top module: `vsync_delay_gen`

## Requirements
- R1: After reset, OVS is low and the staged settings hold the following values: half-line delay 15, pixel offset 0, OHS width 16, line length 858, mode 0. These staged values are in force for the first event without any write.
- R2: The pixel position counts 0 up to line length minus 1 and then wraps. OHS goes high in the clock after position 0 and stays high for exactly the active OHS width in clocks, so OHS rises once per line length.
- R3: When line_ref_in is high in cycle k, the pixel position is 0 in cycle k+1 and OHS rises in cycle k+2 (for a non-zero OHS width).
- R4: A frame event is a rising edge of the selected source, sampled on clk. Mode bit 2 selects the source: 0 picks vsync_in and 1 picks trig_in. Edges on the source that is not selected start nothing.
- R5: Half-line ticks are the cycles in which the pixel position is 0 or is line length divided by 2 (rounded down). The delay counts N such ticks, beginning in the cycle after the event.
- R6: Once N ticks have passed (for N = 0, the event cycle itself counts), the block waits two cycles. It then waits for the next pixel position 0, and raises OVS in the clock after the position equals the pixel offset. As a result, OVS rises exactly offset clocks after an OHS rise.
- R7: If mode bit 1 (asynchronous) and mode bit 0 (interlace) are both 1 at the event, the delay is taken as 0. If only one of the two is set, the programmed delay applies.
- R8: OVS stays high for exactly one active line length in clocks.
- R9: A new event that arrives while a delay is pending restarts the count from the new event.
- R10: Register writes use these addresses: 0 half-line delay (11 bits), 1 pixel offset (8 bits), 2 OHS width (8 bits), 3 mode (3 bits), 4 line length (12 bits). Writes to addresses 0 to 3 reach the timing only at the next event; a pending delay keeps the values it started with. The line length and the source select act at once.
- R11: The OHS width is programmable from 0 to 255 clocks and changes only at an event.
- R12: The largest delay, 0x7FF, waits 2047 half-line ticks before the line alignment of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_in | input | 1 | Input vertical sync |
| trig_in | input | 1 | External trigger |
| line_ref_in | input | 1 | Line-rate reference; high resets the pixel position |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 12 | Register write data |
| ovs_o | output | 1 | Output vertical sync |
| ohs_o | output | 1 | Output horizontal sync |

## Verification
The assertions assume that all inputs are synchronous to clk and that the line length is at least 4. They also assume that the line length is larger than both the pixel offset and the OHS width, so a line start and the offset point occur in every line. The offset check assumes that neither the line length nor line_ref_in changes between an event and its OVS pulse. The stimulus programs line lengths from 260 to 330 with offsets below 256 and widths below 61, and the maximum-delay case uses a 40-clock line with offset 5 and width 4. It pulses line_ref_in and writes the line length only while no delay is pending, then waits several lines before the next event.

// File: rtl/vdg_pkg.sv
package vdg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PEND,
    ST_SEEK,
    ST_HOLD
  } vdg_state_e;

  localparam logic [2:0] ADDR_VDLY = 3'd0;
  localparam logic [2:0] ADDR_POFF = 3'd1;
  localparam logic [2:0] ADDR_OHSW = 3'd2;
  localparam logic [2:0] ADDR_MODE = 3'd3;
  localparam logic [2:0] ADDR_LLEN = 3'd4;

  localparam int MODE_INTL  = 0;
  localparam int MODE_ASYNC = 1;
  localparam int MODE_TRIG  = 2;
  localparam int MODE_W     = 3;
endpackage

// File: rtl/vdg_regs.sv
module vdg_regs
  import vdg_pkg::*;
#(
  parameter int VDLY_W   = 11,
  parameter int POFF_W   = 8,
  parameter int OHSW_W   = 8,
  parameter int LLEN_W   = 12,
  parameter int DATA_W   = 12,
  parameter int VDLY_RST = 15,
  parameter int OHSW_RST = 16,
  parameter int LLEN_RST = 858
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              evt,
  output logic [VDLY_W-1:0] tgt_o,
  output logic [POFF_W-1:0] poff_o,
  output logic [OHSW_W-1:0] ohsw_o,
  output logic [LLEN_W-1:0] llen_o,
  output logic              trig_sel_o
);
  logic [VDLY_W-1:0] stg_vdly;
  logic [POFF_W-1:0] stg_poff;
  logic [OHSW_W-1:0] stg_ohsw;
  logic [MODE_W-1:0] stg_mode;
  logic [LLEN_W-1:0] stg_llen;
  logic              zero_dly;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_vdly <= VDLY_W'(VDLY_RST);
      stg_poff <= '0;
      stg_ohsw <= OHSW_W'(OHSW_RST);
      stg_mode <= '0;
      stg_llen <= LLEN_W'(LLEN_RST);
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_VDLY: stg_vdly <= wr_data[VDLY_W-1:0];
        ADDR_POFF: stg_poff <= wr_data[POFF_W-1:0];
        ADDR_OHSW: stg_ohsw <= wr_data[OHSW_W-1:0];
        ADDR_MODE: stg_mode <= wr_data[MODE_W-1:0];
        ADDR_LLEN: stg_llen <= wr_data[LLEN_W-1:0];
        default:   ;
      endcase
    end
  end

  assign zero_dly = stg_mode[MODE_ASYNC] & stg_mode[MODE_INTL];

  // Frame-level shadow copies, refreshed only on a frame event
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_o  <= VDLY_W'(VDLY_RST);
      poff_o <= '0;
      ohsw_o <= OHSW_W'(OHSW_RST);
    end else if (evt) begin
      tgt_o  <= zero_dly ? '0 : stg_vdly;
      poff_o <= stg_poff;
      ohsw_o <= stg_ohsw;
    end
  end

  assign llen_o     = stg_llen;
  assign trig_sel_o = stg_mode[MODE_TRIG];

  assert_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && stg_mode[MODE_ASYNC] && stg_mode[MODE_INTL]) |=> (tgt_o == '0));

  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> ($stable(tgt_o) && $stable(poff_o) && $stable(ohsw_o)));
endmodule

// File: rtl/vdg_hbase.sv
module vdg_hbase #(
  parameter int LLEN_W = 12,
  parameter int OHSW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_ref,
  input  logic [LLEN_W-1:0] llen,
  input  logic [OHSW_W-1:0] ohsw,
  output logic [LLEN_W-1:0] hpos,
  output logic              half_tick,
  output logic              ohs
);
  localparam int PAD = LLEN_W - OHSW_W;

  logic [LLEN_W-1:0] hpos_q;
  logic [LLEN_W-1:0] last_pos;
  logic              ohs_q;

  assign last_pos = llen - LLEN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)                  hpos_q <= '0;
    else if (line_ref)           hpos_q <= '0;
    else if (hpos_q >= last_pos) hpos_q <= '0;
    else                         hpos_q <= hpos_q + LLEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ohs_q <= 1'b0;
    else        ohs_q <= (hpos_q < {{PAD{1'b0}}, ohsw});
  end

  assign half_tick = (hpos_q == '0) || (hpos_q == (llen >> 1));
  assign hpos      = hpos_q;
  assign ohs       = ohs_q;

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos_q >= llen) |=> (hpos_q == '0));

  assert_ohs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ohs_q) |-> ($past(hpos_q) == '0));

  assert_resync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_ref |=> ##1 (ohs_q || ($past(ohsw) == '0)));
endmodule

// File: rtl/vdg_vdelay.sv
module vdg_vdelay
  import vdg_pkg::*;
#(
  parameter int VDLY_W = 11,
  parameter int POFF_W = 8,
  parameter int LLEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              trig,
  input  logic              trig_sel,
  input  logic [LLEN_W-1:0] hpos,
  input  logic              half_tick,
  input  logic [VDLY_W-1:0] tgt,
  input  logic [POFF_W-1:0] poff,
  input  logic [LLEN_W-1:0] llen,
  output logic              evt,
  output logic              ovs
);
  localparam int PAD = LLEN_W - POFF_W;

  vdg_state_e        state;
  logic [VDLY_W-1:0] cnt;
  logic [LLEN_W-1:0] lcnt;
  logic [LLEN_W-1:0] poff_x;
  logic              src, src_q, seen, ovs_q, fire;

  assign src    = trig_sel ? trig : vsync;
  assign evt    = src & ~src_q;
  assign poff_x = {{PAD{1'b0}}, poff};
  assign fire   = (state == ST_SEEK) && (hpos == poff_x) && (seen || (hpos == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= 1'b0;
    else        src_q <= src;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      lcnt  <= '0;
      seen  <= 1'b0;
      ovs_q <= 1'b0;
    end else if (evt) begin
      state <= ST_PEND;
      cnt   <= '0;
      seen  <= 1'b0;
      ovs_q <= 1'b0;
    end else begin
      case (state)
        ST_PEND: begin
          if (cnt == tgt)     state <= ST_SEEK;
          else if (half_tick) cnt   <= cnt + VDLY_W'(1);
        end
        ST_SEEK: begin
          if (hpos == '0) seen <= 1'b1;
          if (fire) begin
            ovs_q <= 1'b1;
            lcnt  <= '0;
            state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (lcnt >= llen - LLEN_W'(1)) begin
            ovs_q <= 1'b0;
            state <= ST_IDLE;
          end else begin
            lcnt <= lcnt + LLEN_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign ovs = ovs_q;

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (state == ST_PEND && cnt == '0 && !ovs_q));

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PEND) |-> (cnt <= tgt));

  assert_ovs_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovs_q) |-> ($past(state) == ST_SEEK && $past(hpos) == $past(poff_x)));

  assert_hold_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> ovs_q);

  assert_ovs_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovs_q) |-> ($past(evt) || ($past(lcnt) >= $past(llen) - LLEN_W'(1))));
endmodule

// File: rtl/vsync_delay_gen.sv
module vsync_delay_gen #(
  parameter int VDLY_W   = 11,
  parameter int POFF_W   = 8,
  parameter int OHSW_W   = 8,
  parameter int LLEN_W   = 12,
  parameter int DATA_W   = 12,
  parameter int VDLY_RST = 15,
  parameter int OHSW_RST = 16,
  parameter int LLEN_RST = 858
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_in,
  input  logic              trig_in,
  input  logic              line_ref_in,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ovs_o,
  output logic              ohs_o
);
  logic [VDLY_W-1:0] tgt;
  logic [POFF_W-1:0] poff;
  logic [OHSW_W-1:0] ohsw;
  logic [LLEN_W-1:0] llen;
  logic [LLEN_W-1:0] hpos;
  logic              trig_sel, evt, half_tick;

  vdg_regs #(
    .VDLY_W(VDLY_W), .POFF_W(POFF_W), .OHSW_W(OHSW_W), .LLEN_W(LLEN_W),
    .DATA_W(DATA_W), .VDLY_RST(VDLY_RST), .OHSW_RST(OHSW_RST), .LLEN_RST(LLEN_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .evt(evt), .tgt_o(tgt), .poff_o(poff), .ohsw_o(ohsw), .llen_o(llen),
    .trig_sel_o(trig_sel)
  );

  vdg_hbase #(.LLEN_W(LLEN_W), .OHSW_W(OHSW_W)) u_hbase (
    .clk(clk), .rst_n(rst_n), .line_ref(line_ref_in), .llen(llen), .ohsw(ohsw),
    .hpos(hpos), .half_tick(half_tick), .ohs(ohs_o)
  );

  vdg_vdelay #(.VDLY_W(VDLY_W), .POFF_W(POFF_W), .LLEN_W(LLEN_W)) u_vdelay (
    .clk(clk), .rst_n(rst_n), .vsync(vsync_in), .trig(trig_in), .trig_sel(trig_sel),
    .hpos(hpos), .half_tick(half_tick), .tgt(tgt), .poff(poff), .llen(llen),
    .evt(evt), .ovs(ovs_o)
  );
endmodule

// File: tb/vsync_delay_gen_bench.sv
module vsync_delay_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync_in = 1'b0, trig_in = 1'b0, line_ref_in = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic ovs_o, ohs_o;

  vsync_delay_gen u_vsync_delay_gen (
    .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .trig_in(trig_in),
    .line_ref_in(line_ref_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ovs_o(ovs_o), .ohs_o(ohs_o)
  );

  always #5 clk = ~clk;

  int cyc = 0, checks = 0, errors = 0, lb = 858, hb = 0;
  int ohs_rise_cyc = 0, ohs_period = 0, ohs_width = 0;
  int ovs_rise_cyc = 0, ovs_width = 0, ovs_rises = 0, ovs_falls = 0, ovs_gap = 0;
  bit ohs_p = 1'b0, ovs_p = 1'b0, done = 1'b0;
  int ev_cyc = 0, ev_hb = 0;

  always @(posedge clk) cyc = cyc + 1;

  // Port monitor: rebuilds pixel position from OHS rises
  always @(negedge clk) begin
    if (ohs_o && !ohs_p) begin
      ohs_period = cyc - ohs_rise_cyc;
      ohs_rise_cyc = cyc;
      hb = 1;
    end else begin
      hb = (hb + 1) % lb;
    end
    if (!ohs_o && ohs_p) ohs_width = cyc - ohs_rise_cyc;
    if (ovs_o && !ovs_p) begin
      ovs_rise_cyc = cyc;
      ovs_gap = cyc - ohs_rise_cyc;
      ovs_rises++;
    end
    if (!ovs_o && ovs_p) begin
      ovs_width = cyc - ovs_rise_cyc;
      ovs_falls++;
    end
    ohs_p = ohs_o;
    ovs_p = ovs_o;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(logic [2:0] a, int d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = 12'(d);
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire_event(bit use_trig);
    @(negedge clk); #1;
    if (use_trig) trig_in = 1'b1; else vsync_in = 1'b1;
    ev_cyc = cyc;
    ev_hb = hb;
    repeat (3) @(negedge clk);
    #1;
    trig_in = 1'b0;
    vsync_in = 1'b0;
  endtask

  function automatic int predict(int e, int hbe, int n, int off, int l);
    int j = e, k = 0, t = e, h;
    bit seen = 1'b0;
    while (k < n) begin
      j++;
      h = (hbe + (j - e)) % l;
      if (h == 0 || h == l / 2) begin
        k++;
        t = j;
      end
    end
    j = t + 2;
    for (int g = 0; g < 4 * l; g++) begin
      h = (hbe + (j - e)) % l;
      if (h == 0) seen = 1'b1;
      if (seen && h == off) return j + 1;
      j++;
    end
    return -1;
  endfunction

  task automatic wait_ovs_done();
    int r0 = ovs_rises, f0;
    while (ovs_rises == r0) @(negedge clk);
    f0 = ovs_falls;
    while (ovs_falls == f0) @(negedge clk);
  endtask

  task automatic run_case(string tag, int n_eff, int off, bit use_trig);
    int exp;
    fire_event(use_trig);
    exp = predict(ev_cyc, ev_hb, n_eff, off, lb);
    wait_ovs_done();
    chk(ovs_rise_cyc == exp, {tag, " R6 rise"}, ovs_rise_cyc, exp);
    chk(ovs_width == lb, {tag, " R8 width"}, ovs_width, lb);
    chk(ovs_gap == off, {tag, " R6 gap"}, ovs_gap, off);
  endtask

  task automatic set_len(int l);
    wr(3'd4, l);
    lb = l;
    wait_cyc(3 * l);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int k, r0, exp;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(ovs_o == 1'b0, "R1 ovs in reset", ovs_o, 0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    wait_cyc(3 * 858);
    chk(ovs_o == 1'b0, "R1 ovs after reset", ovs_o, 0);
    chk(ohs_width == 16, "R1/R11 default ohs width", ohs_width, 16);
    chk(ohs_period == 858, "R1/R2 default line length", ohs_period, 858);
    // R1: defaults, delay 15, offset 0
    run_case("R1 default", 15, 0, 1'b0);

    set_len(300);
    chk(ohs_period == 300, "R2 period", ohs_period, 300);

    // R3: line reference pulse mid-line
    while (hb != 150) @(negedge clk);
    #1;
    line_ref_in = 1'b1;
    k = cyc;
    @(negedge clk); #1;
    line_ref_in = 1'b0;
    wait_cyc(3);
    chk(ohs_rise_cyc == k + 2, "R3 resync", ohs_rise_cyc, k + 2);
    wait_cyc(2 * 300);

    // R11/R10: width staged until an event
    wr(3'd2, 40);
    wr(3'd0, 2);
    wr(3'd1, 100);
    wait_cyc(2 * 300);
    chk(ohs_width == 16, "R10/R11 width staged", ohs_width, 16);
    run_case("R5", 2, 100, 1'b0);
    chk(ohs_width == 40, "R11 width applied", ohs_width, 40);

    // R7: override when both flags set, not with one
    wr(3'd0, 9);
    wr(3'd1, 7);
    wr(3'd3, 3);
    run_case("R7 both", 0, 7, 1'b0);
    wr(3'd3, 2);
    run_case("R7 async only", 9, 7, 1'b0);
    wr(3'd3, 1);
    run_case("R7 intl only", 9, 7, 1'b0);
    wr(3'd3, 0);

    // R9: retrigger during a pending delay
    wr(3'd0, 10);
    wr(3'd1, 20);
    fire_event(1'b0);
    r0 = ovs_rises;
    wait_cyc(400);
    chk(ovs_rises == r0, "R9 no early ovs", ovs_rises, r0);
    run_case("R9 restart", 10, 20, 1'b0);

    // R10: writes during a pending delay do not alter it
    wr(3'd0, 6);
    wr(3'd1, 30);
    fire_event(1'b0);
    exp = predict(ev_cyc, ev_hb, 6, 30, lb);
    wr(3'd0, 1);
    wr(3'd1, 50);
    wr(3'd2, 20);
    wait_ovs_done();
    chk(ovs_rise_cyc == exp, "R10 pending keeps delay", ovs_rise_cyc, exp);
    chk(ovs_gap == 30, "R10 pending keeps offset", ovs_gap, 30);
    chk(ohs_width == 40, "R10 pending keeps width", ohs_width, 40);
    run_case("R10 next event", 1, 50, 1'b0);
    chk(ohs_width == 20, "R10/R11 new width", ohs_width, 20);

    // R4: source selection
    wr(3'd0, 0);
    wr(3'd3, 4);
    r0 = ovs_rises;
    fire_event(1'b0);
    wait_cyc(3 * 300);
    chk(ovs_rises == r0, "R4 vsync ignored", ovs_rises, r0);
    run_case("R4 trigger", 0, 50, 1'b1);
    wr(3'd3, 0);
    r0 = ovs_rises;
    fire_event(1'b1);
    wait_cyc(3 * 300);
    chk(ovs_rises == r0, "R4 trigger ignored", ovs_rises, r0);
    run_case("R4 vsync", 0, 50, 1'b0);

    // R12: maximum delay on a short line
    wr(3'd2, 4);
    wr(3'd1, 5);
    wr(3'd0, 12'h7FF);
    set_len(40);
    run_case("R12 max", 2047, 5, 1'b0);
    chk(ohs_width == 4, "R11 short width", ohs_width, 4);

    // Random mix
    for (int it = 0; it < 8; it++) begin
      int l = 260 + int'($urandom % 71);
      int n = int'($urandom % 13);
      int off = int'($urandom % 256);
      int w = 1 + int'($urandom % 60);
      int m = int'($urandom % 8);
      wr(3'd0, n);
      wr(3'd1, off);
      wr(3'd2, w);
      wr(3'd3, m);
      set_len(l);
      chk(ohs_period == l, "R2 random period", ohs_period, l);
      run_case("R5/R7 random", ((m & 3) == 3) ? 0 : n, off, m[2]);
      chk(ohs_width == w, "R11 random width", ohs_width, w);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule